// File: doc/BRIEF.md
# Addressed SPI Frame Slave

This block terminates SPI mode-0 frames for a port expander. Several expanders can share one chip select because each compares a three-bit device field in the first byte with its own static address pins. While chip select is low, the first byte selects the device and the transfer direction. The second byte is handed to the register file as a starting register address. Every later byte is either delivered as a write byte or replaced by a byte fetched from the register file and shifted back out.

SCK, MOSI and chip select are brought into the system clock domain through synchronizers, and all edges are detected there. SCK therefore has to be several system clocks per half period. The register file owns the address pointer. It loads the pointer on the address strobe and moves it on each write or read strobe. Its read data is taken in during the cycle of the read strobe.

Top module: `spi_addr_slave`

## Requirements
- R1: Out of reset, regAddrLoad, wrStrobe, rdStrobe and spiMisoOe are all low.
- R2: Bytes are received MSB first, sampled on rising SCK. A frame is accepted when first-byte bits 3:1 equal devAddr and bits 7:4 equal 4'b0100. The second byte of an accepted frame then gives one regAddrLoad pulse with regAddr equal to that byte.
- R3: In an accepted frame whose first-byte bit 0 is 0 (write), every completed byte after the second gives one wrStrobe pulse, with wrData equal to that byte, in arrival order.
- R4: When bits 3:1 of the first byte differ from devAddr, the rest of the frame produces no strobe, and spiMisoOe stays low until chip select rises.
- R5: When bits 7:4 of the first byte differ from 4'b0100, the frame is ignored in the same way as in R4.
- R6: In an accepted frame whose first-byte bit 0 is 1 (read), rdStrobe follows regAddrLoad in the very next cycle. The rdData present in a rdStrobe cycle is shifted out MSB first on spiMiso, changing after falling SCK. Its first bit follows the falling edge that ends the previous byte.
- R7: In a read frame, one rdStrobe is issued after each completed data byte, including the last one. Successive data bytes therefore carry successive register file reads.
- R8: Chip select going high discards a partial byte and ends the frame. Within a few clocks all strobes and spiMisoOe are low, and the next frame starts again with an opcode byte.
- R9: spiMisoOe rises together with regAddrLoad of an accepted read frame. It stays low in write frames and before the data phase.
- R10: regAddrLoad, wrStrobe and rdStrobe are single-cycle pulses, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| devAddr | input | DEV_ADDR_W | Static device address pins |
| spiCsN | input | 1 | Chip select, active low |
| spiSck | input | 1 | Serial clock, idles low |
| spiMosi | input | 1 | Serial data in |
| spiMiso | output | 1 | Serial data out value |
| spiMisoOe | output | 1 | Output enable for spiMiso; low means the pad floats |
| regAddrLoad | output | 1 | Pulse: load the register pointer from regAddr |
| regAddr | output | BYTE_W | Register address byte |
| wrStrobe | output | 1 | Pulse: write wrData at the pointer |
| wrData | output | BYTE_W | Write data byte |
| rdStrobe | output | 1 | Pulse: rdData is taken for transmission |
| rdData | input | BYTE_W | Register file data at the current pointer |

## Verification
The assertions assume that SCK is low whenever chip select changes. They also assume that each SCK half period is longer than the synchronizer depth plus three clocks. Under those conditions a byte completion, its strobe and the read fetch all land before the next SCK edge is seen. The bench drives SCK with a fixed half period of eight clocks, moves MOSI only while SCK is low, and raises chip select only after SCK has returned low. The aborted-frame test keeps SCK low at the point where chip select rises.

// File: rtl/spi_addr_slave_pkg.sv
package spi_addr_slave_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPCODE,
    ST_REGADDR,
    ST_DATA,
    ST_IGNORE
  } frameState_t;

  // control -> datapath
  typedef struct packed {
    logic loadTx;    // capture read data into the transmit shifter
    logic txEnable;  // allow transmit shifting on falling SCK
  } dpCtrl_t;

  // datapath -> control
  typedef struct packed {
    logic csActive;  // synchronized chip select asserted
    logic byteDone;  // one-cycle pulse, rxByte holds a fresh byte
  } dpStatus_t;

endpackage

// File: rtl/spi_addr_slave_sync.sv
module spi_addr_slave_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= {STAGES{RESET_VAL}};
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) begin
        chain[i] <= chain[i-1];
      end
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/spi_addr_slave_dp.sv
module spi_addr_slave_dp
  import spi_addr_slave_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              spiCsN,
  input  logic              spiSck,
  input  logic              spiMosi,
  input  dpCtrl_t           dpCtrl,
  input  logic [BYTE_W-1:0] rdData,
  output dpStatus_t         dpStatus,
  output logic [BYTE_W-1:0] rxByte,
  output logic              spiMiso
);

  localparam int CNT_W = (BYTE_W > 2) ? $clog2(BYTE_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic csS, sckS, mosiS;
  logic sckPrev;
  logic sckRise, sckFall;
  logic csActive;
  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] rxShift;
  logic [BYTE_W-1:0] txShift;
  logic              misoReg;
  logic              byteDone;

  spi_addr_slave_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) uCsSync (
    .clk(clk), .rstN(rstN), .din(spiCsN), .dout(csS)
  );
  spi_addr_slave_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) uSckSync (
    .clk(clk), .rstN(rstN), .din(spiSck), .dout(sckS)
  );
  spi_addr_slave_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) uMosiSync (
    .clk(clk), .rstN(rstN), .din(spiMosi), .dout(mosiS)
  );

  assign csActive = ~csS;
  assign sckRise  = sckS & ~sckPrev;
  assign sckFall  = ~sckS & sckPrev;

  // receive path: bit counter, shifter, byte hand-off
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPrev  <= 1'b0;
      bitCnt   <= '0;
      rxShift  <= '0;
      rxByte   <= '0;
      byteDone <= 1'b0;
    end else begin
      sckPrev  <= sckS;
      byteDone <= 1'b0;
      if (!csActive) begin
        bitCnt  <= '0;
        rxShift <= '0;
      end else if (sckRise) begin
        rxShift <= {rxShift[BYTE_W-2:0], mosiS};
        if (bitCnt == LAST_BIT) begin
          bitCnt   <= '0;
          rxByte   <= {rxShift[BYTE_W-2:0], mosiS};
          byteDone <= 1'b1;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  // transmit path: load on fetch, present one bit per falling edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      misoReg <= 1'b0;
    end else if (dpCtrl.loadTx) begin
      txShift <= rdData;
    end else if (dpCtrl.txEnable && csActive && sckFall) begin
      misoReg <= txShift[BYTE_W-1];
      txShift <= {txShift[BYTE_W-2:0], 1'b0};
    end
  end

  assign spiMiso           = misoReg;
  assign dpStatus.csActive = csActive;
  assign dpStatus.byteDone = byteDone;

endmodule

// File: rtl/spi_addr_slave_ctrl.sv
module spi_addr_slave_ctrl
  import spi_addr_slave_pkg::*;
#(
  parameter int              BYTE_W     = 8,
  parameter int              DEV_ADDR_W = 3,
  parameter int              TAG_W      = 4,
  parameter logic [TAG_W-1:0] OPCODE_TAG = 4'b0100
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [DEV_ADDR_W-1:0] devAddr,
  input  dpStatus_t             dpStatus,
  input  logic [BYTE_W-1:0]     rxByte,
  output dpCtrl_t               dpCtrl,
  output logic                  regAddrLoad,
  output logic                  wrStrobe,
  output logic                  rdStrobe,
  output logic                  misoOe
);

  frameState_t state;
  logic        isRead;
  logic        fetchPend;
  logic        tagOk, addrOk, opMatch;

  assign tagOk   = (rxByte[BYTE_W-1 -: TAG_W] == OPCODE_TAG);
  assign addrOk  = (rxByte[DEV_ADDR_W:1] == devAddr);
  assign opMatch = tagOk & addrOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      isRead      <= 1'b0;
      fetchPend   <= 1'b0;
      regAddrLoad <= 1'b0;
      wrStrobe    <= 1'b0;
      rdStrobe    <= 1'b0;
      misoOe      <= 1'b0;
    end else begin
      regAddrLoad <= 1'b0;
      wrStrobe    <= 1'b0;
      rdStrobe    <= 1'b0;
      if (!dpStatus.csActive) begin
        state     <= ST_IDLE;
        isRead    <= 1'b0;
        fetchPend <= 1'b0;
        misoOe    <= 1'b0;
      end else begin
        rdStrobe  <= fetchPend;
        fetchPend <= 1'b0;
        case (state)
          ST_IDLE, ST_OPCODE: begin
            state <= ST_OPCODE;
            if (dpStatus.byteDone) begin
              if (opMatch) begin
                isRead <= rxByte[0];
                state  <= ST_REGADDR;
              end else begin
                state <= ST_IGNORE;
              end
            end
          end
          ST_REGADDR: begin
            if (dpStatus.byteDone) begin
              regAddrLoad <= 1'b1;
              misoOe      <= isRead;
              fetchPend   <= isRead;
              state       <= ST_DATA;
            end
          end
          ST_DATA: begin
            if (dpStatus.byteDone) begin
              if (isRead) rdStrobe <= 1'b1;
              else        wrStrobe <= 1'b1;
            end
          end
          default: state <= ST_IGNORE;
        endcase
      end
    end
  end

  assign dpCtrl.loadTx   = rdStrobe;
  assign dpCtrl.txEnable = misoOe;

endmodule

// File: rtl/spi_addr_slave.sv
module spi_addr_slave
  import spi_addr_slave_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter int               BYTE_W      = 8,
  parameter int               DEV_ADDR_W  = 3,
  parameter int               TAG_W       = 4,
  parameter logic [TAG_W-1:0] OPCODE_TAG  = 4'b0100
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [DEV_ADDR_W-1:0] devAddr,
  input  logic                  spiCsN,
  input  logic                  spiSck,
  input  logic                  spiMosi,
  output logic                  spiMiso,
  output logic                  spiMisoOe,
  output logic                  regAddrLoad,
  output logic [BYTE_W-1:0]     regAddr,
  output logic                  wrStrobe,
  output logic [BYTE_W-1:0]     wrData,
  output logic                  rdStrobe,
  input  logic [BYTE_W-1:0]     rdData
);

  dpCtrl_t           dpCtrl;
  dpStatus_t         dpStatus;
  logic [BYTE_W-1:0] rxByte;

  spi_addr_slave_dp #(
    .SYNC_STAGES(SYNC_STAGES),
    .BYTE_W     (BYTE_W)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .spiCsN  (spiCsN),
    .spiSck  (spiSck),
    .spiMosi (spiMosi),
    .dpCtrl  (dpCtrl),
    .rdData  (rdData),
    .dpStatus(dpStatus),
    .rxByte  (rxByte),
    .spiMiso (spiMiso)
  );

  spi_addr_slave_ctrl #(
    .BYTE_W    (BYTE_W),
    .DEV_ADDR_W(DEV_ADDR_W),
    .TAG_W     (TAG_W),
    .OPCODE_TAG(OPCODE_TAG)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .devAddr    (devAddr),
    .dpStatus   (dpStatus),
    .rxByte     (rxByte),
    .dpCtrl     (dpCtrl),
    .regAddrLoad(regAddrLoad),
    .wrStrobe   (wrStrobe),
    .rdStrobe   (rdStrobe),
    .misoOe     (spiMisoOe)
  );

  assign regAddr = rxByte;
  assign wrData  = rxByte;

endmodule

// File: rtl/spi_addr_slave_chk.sv
module spi_addr_slave_chk #(
  parameter int SYNC_STAGES = 2
) (
  input logic clk,
  input logic rstN,
  input logic spiCsN,
  input logic spiMisoOe,
  input logic regAddrLoad,
  input logic wrStrobe,
  input logic rdStrobe
);

  localparam int SETTLE = SYNC_STAGES + 1;
  localparam int CNT_W  = $clog2(SETTLE + 2);

  logic [CNT_W-1:0] csHighCnt;
  logic             csSettled;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       csHighCnt <= '0;
    else if (!spiCsN)                csHighCnt <= '0;
    else if (csHighCnt < CNT_W'(SETTLE)) csHighCnt <= csHighCnt + 1'b1;
  end

  assign csSettled = (csHighCnt >= CNT_W'(SETTLE));

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({regAddrLoad, wrStrobe, rdStrobe})); // R10
  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe); // R10
  AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    regAddrLoad |=> !regAddrLoad); // R10
  AST_RD_FOLLOWS_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (regAddrLoad && spiMisoOe) |=> rdStrobe); // R6
  AST_RD_NEEDS_OE: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe |-> spiMisoOe); // R9
  AST_WR_NO_OE: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> !spiMisoOe); // R9
  AST_OE_RISES_AT_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(spiMisoOe) |-> regAddrLoad); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    csSettled |-> !(spiMisoOe || regAddrLoad || wrStrobe || rdStrobe)); // R8

endmodule

bind spi_addr_slave spi_addr_slave_chk #(.SYNC_STAGES(SYNC_STAGES)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .spiCsN     (spiCsN),
  .spiMisoOe  (spiMisoOe),
  .regAddrLoad(regAddrLoad),
  .wrStrobe   (wrStrobe),
  .rdStrobe   (rdStrobe)
);

// File: tb/tb_spi_addr_slave.sv
module tb_spi_addr_slave;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam logic [2:0] MY_ADDR = 3'b101;

  typedef struct packed {
    logic [7:0] op;
    logic [7:0] ra;
    logic [7:0] d0;
    logic [7:0] d1;
    logic       hit;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VEC [NVEC] = '{
    '{8'h4A, 8'h12, 8'hA5, 8'h3C, 1'b1},  // write, match
    '{8'h4B, 8'h20, 8'h00, 8'h00, 1'b1},  // read, match
    '{8'h48, 8'h30, 8'h11, 8'h22, 1'b0},  // device field 100
    '{8'h43, 8'h40, 8'h00, 8'h00, 1'b0},  // device field 001, read
    '{8'h5A, 8'h50, 8'h33, 8'h44, 1'b0},  // tag 0101
    '{8'hCB, 8'h60, 8'h00, 8'h00, 1'b0},  // tag 1100, read
    '{8'h4A, 8'hFF, 8'h00, 8'hFF, 1'b1},  // write, edge values
    '{8'h4B, 8'h7E, 8'hFF, 8'hFF, 1'b1},  // read
    '{8'h4E, 8'h01, 8'h55, 8'hAA, 1'b0}   // device field 111
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       spiCsN = 1'b1, spiSck = 1'b0, spiMosi = 1'b0;
  logic       spiMiso, spiMisoOe, regAddrLoad, wrStrobe, rdStrobe;
  logic [7:0] regAddr, wrData, rdData;
  logic [7:0] ptr = 8'h00;

  int nChecks = 0, nErrors = 0;
  int cyc = 0;
  bit finished = 0;

  // monitor records
  int         loadCnt, wrCnt, rdCnt, gap, loadCyc;
  logic [7:0] lastAddr;
  logic [7:0] wrBytes [4];
  bit         oeSeen, oeEarly;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_addr_slave dut (
    .clk(clk), .rstN(rstN), .devAddr(MY_ADDR),
    .spiCsN(spiCsN), .spiSck(spiSck), .spiMosi(spiMosi),
    .spiMiso(spiMiso), .spiMisoOe(spiMisoOe),
    .regAddrLoad(regAddrLoad), .regAddr(regAddr),
    .wrStrobe(wrStrobe), .wrData(wrData),
    .rdStrobe(rdStrobe), .rdData(rdData)
  );

  function automatic logic [7:0] memVal(input logic [7:0] a);
    return (a * 8'd37) ^ 8'hC3;
  endfunction

  // register file model: pointer load and advance
  assign rdData = memVal(ptr);
  always @(posedge clk) begin
    if (regAddrLoad) ptr <= regAddr;
    else if (rdStrobe || wrStrobe) ptr <= ptr + 8'd1;
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (regAddrLoad) begin
      loadCnt  = loadCnt + 1;
      lastAddr = regAddr;
      loadCyc  = cyc;
    end
    if (wrStrobe) begin
      if (wrCnt < 4) wrBytes[wrCnt] = wrData;
      wrCnt = wrCnt + 1;
    end
    if (rdStrobe) begin
      if (rdCnt == 0) gap = cyc - loadCyc;
      rdCnt = rdCnt + 1;
    end
    if (spiMisoOe) begin
      oeSeen = 1;
      if (loadCnt == 0) oeEarly = 1;
    end
  end

  task automatic clearMon();
    loadCnt = 0; wrCnt = 0; rdCnt = 0; gap = -1; loadCyc = 0;
    lastAddr = 8'h00; oeSeen = 0; oeEarly = 0;
    for (int i = 0; i < 4; i++) wrBytes[i] = 8'h00;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic spiByte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      spiMosi = tx[i];
      repeat (HALF) @(negedge clk);
      spiSck = 1'b1;
      rx[i]  = spiMiso;
      repeat (HALF) @(negedge clk);
      spiSck = 1'b0;
    end
  endtask

  task automatic frame(input vec_t v, output logic [7:0] r0, output logic [7:0] r1);
    logic [7:0] junk;
    clearMon();
    spiCsN = 1'b0;
    repeat (HALF) @(negedge clk);
    spiByte(v.op, junk);
    spiByte(v.ra, junk);
    spiByte(v.d0, r0);
    spiByte(v.d1, r1);
    repeat (HALF) @(negedge clk);
    spiCsN = 1'b1;
    repeat (6*HALF) @(negedge clk);
  endtask

  always @(posedge clk) begin
    if (cyc > 150000 && !finished) begin
      finished = 1;
      nChecks++; nErrors++;
      $display("FAIL watchdog R1..R10 run actual=%0d expected=done", cyc);
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r0, r1, junk;
    clearMon();
    repeat (5) @(negedge clk);
    // R1: reset state
    check("R1 strobes in reset", {regAddrLoad, wrStrobe, rdStrobe}, 3'b000);
    check("R1 oe in reset", spiMisoOe, 1'b0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 strobes after reset", {regAddrLoad, wrStrobe, rdStrobe, spiMisoOe}, 4'b0000);

    for (int k = 0; k < NVEC; k++) begin
      frame(VEC[k], r0, r1);
      if (!VEC[k].hit) begin
        // R4 and R5: mismatched opcode ignored
        check(VEC[k].op[7:4] == 4'b0100 ? "R4 no load" : "R5 no load", loadCnt, 0);
        check(VEC[k].op[7:4] == 4'b0100 ? "R4 no data strobe" : "R5 no data strobe", wrCnt + rdCnt, 0);
        check(VEC[k].op[7:4] == 4'b0100 ? "R4 oe low" : "R5 oe low", oeSeen, 0);
      end else begin
        check("R2 one address load", loadCnt, 1);
        check("R2 address value", lastAddr, VEC[k].ra);
        if (!VEC[k].op[0]) begin
          check("R3 write count", wrCnt, 2);
          check("R3 first write byte", wrBytes[0], VEC[k].d0);
          check("R3 second write byte", wrBytes[1], VEC[k].d1);
          check("R9 oe low in write", oeSeen, 0);
          check("R3 no read strobe", rdCnt, 0);
        end else begin
          check("R6 load to fetch gap", gap, 1);
          check("R6 first read byte", r0, memVal(VEC[k].ra));
          check("R7 second read byte", r1, memVal(VEC[k].ra + 8'd1));
          check("R7 fetch count", rdCnt, 3);
          check("R9 oe during data", oeSeen, 1);
          check("R9 oe not before load", oeEarly, 0);
        end
      end
    end

    // R8: partial byte then chip select high; next frame starts cleanly
    clearMon();
    spiCsN = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      spiMosi = 1'b1;
      repeat (HALF) @(negedge clk);
      spiSck = 1'b1;
      repeat (HALF) @(negedge clk);
      spiSck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    spiCsN = 1'b1;
    repeat (6*HALF) @(negedge clk);
    check("R8 aborted frame quiet", loadCnt + wrCnt + rdCnt, 0);
    frame('{8'h4A, 8'h33, 8'h77, 8'h88, 1'b1}, r0, r1);
    check("R8 address after abort", lastAddr, 8'h33);
    check("R8 write after abort", wrBytes[0], 8'h77);

    // R8: read frame aborted inside a data byte drops oe and strobes
    clearMon();
    spiCsN = 1'b0;
    repeat (HALF) @(negedge clk);
    spiByte(8'h4B, junk);
    spiByte(8'h05, junk);
    for (int i = 0; i < 3; i++) begin
      repeat (HALF) @(negedge clk);
      spiSck = 1'b1;
      repeat (HALF) @(negedge clk);
      spiSck = 1'b0;
    end
    spiCsN = 1'b1;
    repeat (6*HALF) @(negedge clk);
    check("R8 oe released", spiMisoOe, 1'b0);
    check("R10 single fetch before abort", rdCnt, 1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule